// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a small two-plane cursor image over a stream of palette-indexed pixels. Software loads a 32x32 cursor through a 32-bit register port: one plane says which cursor pixels are opaque, and the other picks between two overlay colors. Software also loads the cursor's top-left screen position. The pixel stream carries an x/y coordinate and a base palette index with every pixel. For each pixel the block forwards either that base index or one of two fixed overlay palette entries, 258 or 259. The palette lookup downstream turns the result into a color.

The cursor is drawn only over the rows and columns it covers. It is clipped at the right edge of the active screen, and it is hidden completely when its x position is at or beyond the screen width. After reset the cursor sits far off screen, so a fresh block passes every pixel through unchanged. A miscellaneous status register can be written and read back, and reads of it always show one fixed flag bit set.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor x position is 0xF000 and both planes are all zero, so every pixel passes through with its base index.
- R2: A write to offset 0x8FC loads the cursor x position from data bits 31:16 and the cursor y position from data bits 15:0.
- R3: Writes to offsets 0x900-0x97F load opaque-plane row (offset-0x900)>>2. Writes to offsets 0x980-0x9FF load color-plane row (offset-0x980)>>2. The low two offset bits are ignored.
- R4: In each plane row, data bit 31 is the leftmost cursor column and each lower bit is the next column to the right.
- R5: Over a covered pixel, opaque bit 1 with color bit 1 gives index 259, and opaque bit 1 with color bit 0 gives index 258. Opaque bit 0 forwards the base index, zero-extended to 9 bits.
- R6: The cursor covers only screen rows from its y position through y position + 31.
- R7: The cursor is drawn only while its x position is less than the screen width input.
- R8: The horizontal span covers columns from the x position up to, but not including, the smaller of x position + 32 and the screen width. Pixels at or beyond the screen width always pass through.
- R9: Offset 0x818 stores written data. A read of it returns the stored value ORed with 0x02000000.
- R10: Reads of any offset other than 0x818 return zero. Writes to offsets outside 0x818, 0x8FC and 0x900-0x9FF change nothing.
- R11: Each valid pixel produces out_valid and its out_index exactly one clock later, whether or not the cursor covers it. An idle input cycle produces an idle output cycle.
- R12: Read data appears on reg_rdata one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| scr_width | input | 16 | Active screen width in pixels |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_base | input | 8 | Base palette index of the input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_index | output | 9 | Resulting palette index |

## Verification
Pixels are placed on each corner column of a cursor row with a sparse opaque pattern, one column inside each edge and one column past each edge. This separates the bit ordering of a row from an off-by-one in the span. The first, last and one-past-last rows, a row loaded through a misaligned offset, and a row with mixed color bits separate row selection from plane selection. A cursor placed near the right edge is re-run under two screen widths, and a cursor parked at the width is made visible by widening the screen; these patterns distinguish clipping from the visibility test. Back-to-back pixels, idle gaps, unmapped writes and register reads show that latency is fixed and that stray accesses leave the image untouched.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int COORD_W = 16;
    localparam int BASE_W  = 8;
    localparam int OUT_W   = 9;
    localparam int CUR_DIM = 32;
    localparam int ROW_W   = $clog2(CUR_DIM);

    localparam logic [ADDR_W-1:0] OFF_MISC  = 12'h818;
    localparam logic [ADDR_W-1:0] OFF_POS   = 12'h8FC;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h900;
    localparam logic [ADDR_W-1:0] OFF_COLR  = 12'h980;
    localparam logic [ADDR_W-1:0] PLANE_SPAN = ADDR_W'(CUR_DIM * 4);

    localparam logic [DATA_W-1:0]  MISC_FLAG = 32'h0200_0000;
    localparam logic [COORD_W-1:0] PARK_X    = 16'hF000;
    localparam logic [OUT_W-1:0]   ENT_BG    = 9'd258;
    localparam logic [OUT_W-1:0]   ENT_FG    = 9'd259;

    typedef logic [CUR_DIM-1:0] cur_row_t;
    typedef cur_row_t [CUR_DIM-1:0] cur_plane_t;

endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
    import cursor_ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output cur_plane_t         mask_plane,
    output cur_plane_t         colr_plane
);

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [DATA_W-1:0]  misc;
        cur_plane_t         mask;
        cur_plane_t         colr;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{x: PARK_X, y: '0, misc: '0,
                                   mask: '0, colr: '0, rdata: '0};

    regs_t st_d, st_q;

    logic [ADDR_W-1:0] mask_off_d, colr_off_d;
    logic [ROW_W-1:0]  mask_row_d, colr_row_d;
    logic              in_mask_d, in_colr_d, is_pos_d, is_misc_d, mapped_d;

    always_comb begin
        mask_off_d = reg_addr - OFF_MASK;
        colr_off_d = reg_addr - OFF_COLR;
        mask_row_d = ROW_W'(mask_off_d >> 2);
        colr_row_d = ROW_W'(colr_off_d >> 2);
        in_mask_d  = (reg_addr >= OFF_MASK) && (reg_addr < OFF_MASK + PLANE_SPAN);
        in_colr_d  = (reg_addr >= OFF_COLR) && (reg_addr < OFF_COLR + PLANE_SPAN);
        is_pos_d   = (reg_addr == OFF_POS);
        is_misc_d  = (reg_addr == OFF_MISC);
        mapped_d   = in_mask_d || in_colr_d || is_pos_d || is_misc_d;

        st_d = st_q;
        if (reg_wr) begin
            if (is_pos_d) begin
                st_d.x = reg_wdata[DATA_W-1 -: COORD_W];
                st_d.y = reg_wdata[COORD_W-1:0];
            end else if (in_mask_d) begin
                st_d.mask[mask_row_d] = reg_wdata[DATA_W-1 -: CUR_DIM];
            end else if (in_colr_d) begin
                st_d.colr[colr_row_d] = reg_wdata[DATA_W-1 -: CUR_DIM];
            end else if (is_misc_d) begin
                st_d.misc = reg_wdata;
            end
        end
        if (reg_rd) begin
            st_d.rdata = is_misc_d ? (st_q.misc | MISC_FLAG) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.rdata;
    assign cur_x      = st_q.x;
    assign cur_y      = st_q.y;
    assign mask_plane = st_q.mask;
    assign colr_plane = st_q.colr;

    // R1
    reset_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_x == PARK_X && mask_plane == '0));

    // R2
    pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_POS) |=> ({cur_x, cur_y} == $past(reg_wdata)));

    // R9
    misc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_MISC) |=> ((reg_rdata & MISC_FLAG) == MISC_FLAG));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != OFF_MISC) |=> (reg_rdata == '0));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mapped_d) |=> ($stable(cur_x) && $stable(cur_y) &&
                                   $stable(mask_plane) && $stable(colr_plane)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: rtl/cursor_ovl_hit.sv
module cursor_ovl_hit
    import cursor_ovl_pkg::*;
(
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] scr_width,
    input  cur_plane_t         mask_plane,
    input  cur_plane_t         colr_plane,
    output logic               ovl_hit,
    output logic               ovl_fg
);

    localparam logic [COORD_W:0]  DIM_EXT = (COORD_W+1)'(CUR_DIM);
    localparam logic [ROW_W-1:0]  LAST_COL = ROW_W'(CUR_DIM - 1);

    logic [COORD_W:0] dx, dy;
    logic [ROW_W-1:0] row, col, bitpos;
    logic             row_in, col_in, shown;
    cur_row_t         mask_row, colr_row;

    always_comb begin
        dx     = {1'b0, pix_x} - {1'b0, cur_x};
        dy     = {1'b0, pix_y} - {1'b0, cur_y};
        row_in = (pix_y >= cur_y) && (dy < DIM_EXT);
        col_in = (pix_x >= cur_x) && (dx < DIM_EXT) && (pix_x < scr_width);
        shown  = (cur_x < scr_width);
        row    = dy[ROW_W-1:0];
        col    = dx[ROW_W-1:0];
        bitpos = LAST_COL - col;
        mask_row = mask_plane[row];
        colr_row = colr_plane[row];
        ovl_hit  = row_in && col_in && shown && mask_row[bitpos];
        ovl_fg   = colr_row[bitpos];
    end

endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix
    import cursor_ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [BASE_W-1:0] pix_base,
    input  logic              ovl_hit,
    input  logic              ovl_fg,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_index
);

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] index;
    } mix_t;

    mix_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = pix_valid;
        if (pix_valid) begin
            if (ovl_hit) st_d.index = ovl_fg ? ENT_FG : ENT_BG;
            else         st_d.index = OUT_W'(pix_base);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_index = st_q.index;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R11
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R5
    entry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_index < OUT_W'(256) || out_index == ENT_BG || out_index == ENT_FG));

    // R5
    fg_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ovl_hit && ovl_fg) |=> (out_index == ENT_FG));

    // R5
    pass_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !ovl_hit) |=> (out_index == OUT_W'($past(pix_base))));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [COORD_W-1:0] scr_width,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [BASE_W-1:0]  pix_base,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_index
);

    logic [COORD_W-1:0] cur_x, cur_y;
    cur_plane_t         mask_plane, colr_plane;
    logic               ovl_hit, ovl_fg;

    cursor_ovl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .mask_plane (mask_plane),
        .colr_plane (colr_plane)
    );

    cursor_ovl_hit u_hit (
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .scr_width  (scr_width),
        .mask_plane (mask_plane),
        .colr_plane (colr_plane),
        .ovl_hit    (ovl_hit),
        .ovl_fg     (ovl_fg)
    );

    cursor_ovl_mix u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_base  (pix_base),
        .ovl_hit   (ovl_hit),
        .ovl_fg    (ovl_fg),
        .out_valid (out_valid),
        .out_index (out_index)
    );

    // R6
    above_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_y < cur_y) |=> (out_index == OUT_W'($past(pix_base))));

    // R6
    below_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ({1'b0, pix_y} >= {1'b0, cur_y} + (COORD_W+1)'(CUR_DIM)))
        |=> (out_index == OUT_W'($past(pix_base))));

    // R7
    hidden_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cur_x >= scr_width) |=> (out_index == OUT_W'($past(pix_base))));

    // R8
    beyond_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x >= scr_width) |=> (out_index == OUT_W'($past(pix_base))));

endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] scr_width = 16'd1024;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [7:0]  pix_base = '0;
    logic        out_valid;
    logic [8:0]  out_index;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_x = 16'hF000, m_y = 16'h0;
    logic [31:0] m_mask [32];
    logic [31:0] m_colr [32];

    logic [8:0] exp_val [$];
    string      exp_tag [$];

    always #4 clk = ~clk;

    cursor_overlay dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scr_width(scr_width), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_base(pix_base), .out_valid(out_valid),
        .out_index(out_index)
    );

    function automatic logic [8:0] model(input logic [15:0] x, input logic [15:0] y,
                                         input logic [7:0] base);
        logic [16:0] ex, ey;
        ex = {1'b0, x} - {1'b0, m_x};
        ey = {1'b0, y} - {1'b0, m_y};
        if (m_x < scr_width && x < scr_width && x >= m_x && y >= m_y &&
            ex < 17'd32 && ey < 17'd32) begin
            if (m_mask[ey[4:0]][31 - ex[4:0]])
                return m_colr[ey[4:0]][31 - ex[4:0]] ? 9'd259 : 9'd258;
        end
        return {1'b0, base};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_val.size() == 0) begin
                check("R11 unexpected output", 32'(out_index), 32'h1FF_FFFF);
            end else begin
                logic [8:0] ev;
                string      et;
                ev = exp_val.pop_front();
                et = exp_tag.pop_front();
                check(et, 32'(out_index), 32'(ev));
            end
        end
    end

    task automatic send_px(input string tag, input logic [15:0] x, input logic [15:0] y,
                           input logic [7:0] base);
        pix_valid = 1'b1; pix_x = x; pix_y = y; pix_base = base;
        exp_val.push_back(model(x, y, base));
        exp_tag.push_back(tag);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        pix_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 12'h8FC) begin
            m_x = d[31:16]; m_y = d[15:0];
        end else if (a >= 12'h900 && a < 12'h980) begin
            m_mask[(a - 12'h900) >> 2] = d;
        end else if (a >= 12'h980 && a < 12'hA00) begin
            m_colr[(a - 12'h980) >> 2] = d;
        end
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] expv);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, reg_rdata, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_colr[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 flag on reset value, R12 read timing
        rd("R9 R12 misc after reset", 12'h818, 32'h0200_0000);
        send_px("R1 reset passthrough", 16'd0, 16'd0, 8'h05);
        send_px("R1 reset passthrough", 16'd10, 16'd3, 8'hAA);
        wr(12'h8FC, 32'h0000_0000);
        send_px("R1 planes cleared", 16'd0, 16'd0, 8'h07);
        send_px("R1 planes cleared", 16'd31, 16'd31, 8'h08);

        // R2 R4 R5 corner columns of row 0
        wr(12'h8FC, 32'h0064_0032);
        wr(12'h900, 32'h8000_0001);
        wr(12'h980, 32'h8000_0000);
        send_px("R4 R5 left column fg", 16'd100, 16'd50, 8'h03);
        send_px("R4 R5 right column bg", 16'd131, 16'd50, 8'h03);
        send_px("R5 transparent", 16'd101, 16'd50, 8'h03);
        send_px("R8 left of span", 16'd99, 16'd50, 8'h03);
        send_px("R8 right of span", 16'd132, 16'd50, 8'h03);

        // R3 R6 last row, mixed colors, misaligned offset
        wr(12'h97C, 32'hFFFF_FFFF);
        wr(12'h9FC, 32'h0000_FFFF);
        wr(12'h905, 32'h4000_0000);
        send_px("R6 last row", 16'd110, 16'd81, 8'h09);
        send_px("R3 color plane col16", 16'd116, 16'd81, 8'h09);
        send_px("R3 color plane col15", 16'd115, 16'd81, 8'h09);
        send_px("R6 row past end", 16'd110, 16'd82, 8'h09);
        send_px("R6 row above", 16'd100, 16'd49, 8'h09);
        send_px("R3 misaligned row1", 16'd101, 16'd51, 8'h09);
        send_px("R3 misaligned row1 neighbour", 16'd100, 16'd51, 8'h09);

        // R8 right edge clipping
        wr(12'h8FC, 32'h03F2_0000);
        wr(12'h900, 32'hFFFF_FFFF);
        wr(12'h980, 32'h0000_0000);
        send_px("R8 inside clip", 16'd1013, 16'd0, 8'h01);
        send_px("R8 last screen column", 16'd1023, 16'd0, 8'h01);
        send_px("R8 at width", 16'd1024, 16'd0, 8'h01);
        send_px("R8 beyond width", 16'd1030, 16'd0, 8'h01);
        scr_width = 16'd1020;
        send_px("R8 narrower last column", 16'd1019, 16'd0, 8'h01);
        send_px("R8 narrower at width", 16'd1020, 16'd0, 8'h01);
        scr_width = 16'd1024;

        // R7 visibility
        wr(12'h8FC, 32'h0400_0000);
        send_px("R7 hidden at width", 16'd1024, 16'd0, 8'h02);
        send_px("R7 hidden beyond", 16'd1040, 16'd0, 8'h02);
        scr_width = 16'd2000;
        send_px("R7 shown after widening", 16'd1024, 16'd0, 8'h02);
        scr_width = 16'd1024;

        // R10 unmapped access
        rd("R10 position reads zero", 12'h8FC, 32'h0);
        rd("R10 plane reads zero", 12'h900, 32'h0);
        rd("R10 unmapped read", 12'h004, 32'h0);
        wr(12'hA00, 32'hFFFF_FFFF);
        wr(12'h004, 32'h1234_5678);
        wr(12'h8F8, 32'h0000_0000);
        wr(12'h8FC, 32'h0000_0000);
        send_px("R10 stray writes ignored", 16'd0, 16'd1, 8'h44);
        send_px("R10 stray writes ignored", 16'd0, 16'd0, 8'h44);
        rd("R10 misc untouched", 12'h818, 32'h0200_0000);
        wr(12'h818, 32'h0000_0011);
        rd("R9 misc readback", 12'h818, 32'h0200_0011);

        // R11 back-to-back and idle gaps
        for (int i = 0; i < 40; i++) send_px("R11 stream", 16'(i), 16'(i % 3), 8'(i * 7));
        idle(1);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle: actual %0b expected 0", out_valid);
        end
        send_px("R11 after gap", 16'd5, 16'd0, 8'h66);
        idle(3);
        check("R11 queue drained", 32'(exp_val.size()), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule